// File: doc/BRIEF.md
# Sector Lock and Write-Protect Gate

This block decides whether each program, erase or read request to a 1 MByte flash array may go ahead. The array is divided into sixteen 64 KByte blocks. Three of these blocks are split further into sixteen 4 KByte sectors. Every sector in a split block has its own lock register. Every other block has a single lock register that covers the whole block. A build-time variant chooses which three blocks are split.

Each lock register holds two bits:
- A write-lock bit, which blocks program and erase.
- A read-lock bit, which blocks reads. A blocked read returns zero and raises a violation flag.

An active-low hardware write-protect level also blocks program and erase to every block except the top one. The level is captured when an operation starts and is held until the array reports that the operation is complete.

Each request gets a one-cycle-later verdict of grant or reject. A sticky error bit records every rejection until it is cleared. The lock registers can be written and read back through a dedicated port. They are cleared at reset and again whenever the power-valid input drops.

Top module: `lockgate_top`

## Requirements
- R1: The block number is address bits [19:16] and the sector number is bits [15:12]. With VARIANT_B=0, blocks 0, 14 and 15 are split into sectors. With VARIANT_B=1, blocks 0, 1 and 15 are split. Each sector of a split block has its own lock register, and each unsplit block has one register for all of its addresses.
- R2: A lock register holds bit 0 = write-lock and bit 1 = read-lock. It is written by `lk_we` with `lk_wdata` at the region containing `lk_addr`. `lk_rdata` shows, with no added delay, the register of the region containing `lk_addr`.
- R3: Operation codes are 00 = read, 01 = program, 10 = erase and 11 = reserved. A reserved request is always rejected. Each request produces `resp_valid` one cycle later, with exactly one of `resp_grant` or `resp_reject` set.
- R4: While the effective write-protect level is low, program and erase to blocks 0 through 14 are rejected whatever the lock registers hold.
- R5: Program and erase to block 15 do not depend on the write-protect level.
- R6: While the effective write-protect level is high, a program or erase is granted exactly when the region's write-lock bit is clear.
- R7: A read is rejected exactly when the region's read-lock bit is set. A rejected read sets `rd_viol` and returns `resp_rdata` = 00h. A granted read returns the `arr_rdata` value present with the request. Reads ignore write-protect and the write-lock bit.
- R8: A program or erase granted while idle captures `wp_level` and sets `op_busy`, which stays set until `op_done`. While `op_busy` is set, decisions use the captured level, not the live pin.
- R9: Reset clears all lock registers and `op_busy`. A cycle with `pwr_ok` low clears all lock registers and `op_busy`, and any lock write in that cycle is discarded.
- R10: `prot_err` is set by every rejection and stays set until an `err_clr` cycle that has no new rejection. A rejection in the same cycle as `err_clr` wins.
- R11: A request in the same cycle as a lock write to its region is judged against the lock value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply valid; low clears locks and busy |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 20 | Byte address of the request |
| req_op | input | 2 | Operation code |
| arr_rdata | input | 8 | Array data for a read request |
| wp_level | input | 1 | Write-protect pin, low protects |
| op_done | input | 1 | Array finished the running program/erase |
| lk_we | input | 1 | Lock register write strobe |
| lk_addr | input | 20 | Address selecting the lock register to write or read |
| lk_wdata | input | 2 | Lock value {read-lock, write-lock} |
| err_clr | input | 1 | Clears the sticky error |
| resp_valid | output | 1 | Verdict is present |
| resp_grant | output | 1 | Request allowed |
| resp_reject | output | 1 | Request refused |
| resp_rdata | output | 8 | Read data, 00h on refused read |
| rd_viol | output | 1 | Read refused by a read-lock |
| prot_err | output | 1 | Sticky rejection flag |
| op_busy | output | 1 | Program/erase in progress |
| lk_rdata | output | 2 | Lock readback for `lk_addr` |

## Verification
The hardest case to reach is a request that depends on the held write-protect level. An operation has to be granted with the pin high. The pin then has to fall while `op_busy` stays set, and a second program to an unprotected block must then be granted even though the live pin says otherwise. The stimulus builds this sequence on purpose, then pulses `op_done` and repeats the same request to show it is now refused.

Two instances, one of each variant, run side by side against a sector-level reference model. This exposes the case where one lock write covers a whole block in one variant but a single sector in the other. A long random phase then mixes lock writes, power drops and `err_clr` with requests in the same cycle.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  // bit 1 = read-lock, bit 0 = write-lock
  typedef struct packed {
    logic rd_lock;
    logic wr_lock;
  } lock_t;

  // Which blocks are split into sectors for the chosen variant.
  function automatic logic blk_is_sectored(int unsigned blk, int unsigned nblk, bit variant_b);
    if (variant_b) return (blk == 0) || (blk == 1) || (blk == nblk - 1);
    else           return (blk == 0) || (blk == nblk - 2) || (blk == nblk - 1);
  endfunction

  // First lock-register index of a block: every block below contributes
  // either one register or one per sector.
  function automatic int unsigned region_base(int unsigned blk, int unsigned nblk,
                                              int unsigned nsec, bit variant_b);
    int unsigned acc;
    acc = 0;
    for (int unsigned b = 0; b < nblk; b++) begin
      if (b < blk) acc += blk_is_sectored(b, nblk, variant_b) ? nsec : 1;
    end
    return acc;
  endfunction

  function automatic logic is_pe(op_e op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

  // Verdict for one request against its lock register.
  function automatic logic verdict(op_e op, lock_t lk, logic wp_eff, logic top_blk);
    case (op)
      OP_READ:           return !lk.rd_lock;
      OP_PROG, OP_ERASE: return !lk.wr_lock && (wp_eff || top_blk);
      default:           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lockgate_map.sv
module lockgate_map
  import lockgate_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS   = 16,
  parameter int unsigned SECT_PER_BLK = 16,
  parameter bit          VARIANT_B    = 1'b0,
  parameter int unsigned BLK_BITS     = 4,
  parameter int unsigned SEC_BITS     = 4,
  parameter int unsigned IDX_W        = 6
) (
  input  logic [BLK_BITS-1:0] blk,
  input  logic [SEC_BITS-1:0] sec,
  output logic [IDX_W-1:0]    idx
);

  logic [IDX_W-1:0] base_tab  [NUM_BLOCKS];
  logic             split_tab [NUM_BLOCKS];

  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      localparam int unsigned BASE = region_base(b, NUM_BLOCKS, SECT_PER_BLK, VARIANT_B);
      assign base_tab[b]  = IDX_W'(BASE);
      assign split_tab[b] = blk_is_sectored(b, NUM_BLOCKS, VARIANT_B);
    end
  endgenerate

  assign idx = base_tab[blk] + (split_tab[blk] ? IDX_W'(sec) : '0);

endmodule

// File: rtl/lockgate_regs.sv
module lockgate_regs
  import lockgate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 61,
  parameter int unsigned IDX_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  lock_t            wdata,
  input  logic [IDX_W-1:0] ridx_req,
  input  logic [IDX_W-1:0] ridx_lk,
  output lock_t            lock_req,
  output lock_t            lock_lk
);

  lock_t                  q [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit;

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_dec
      assign hit[r] = we && (widx == IDX_W'(r));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGIONS; r++) q[r] <= '0;
    end else if (!pwr_ok) begin
      for (int r = 0; r < NUM_REGIONS; r++) q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) if (hit[r]) q[r] <= wdata;
    end
  end

  assign lock_req = q[ridx_req];
  assign lock_lk  = q[ridx_lk];

endmodule

// File: rtl/lockgate_decide.sv
module lockgate_decide
  import lockgate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_top,
  input  lock_t             lock,
  input  logic              wp_level,
  input  logic              op_done,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              err_clr,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_reject,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              rd_viol,
  output logic              prot_err,
  output logic              op_busy,
  output logic              wp_held,
  output logic              ev_start_pe,
  output logic              ev_reject
);

  op_e  op;
  logic wp_eff;
  logic allow;
  logic ev_rd_block;

  assign op          = op_e'(req_op);
  assign wp_eff      = op_busy ? wp_held : wp_level;
  assign allow       = verdict(op, lock, wp_eff, req_top);
  assign ev_reject   = req_valid && !allow;
  assign ev_rd_block = req_valid && (op == OP_READ) && !allow;
  assign ev_start_pe = req_valid && allow && is_pe(op) && !op_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_grant  <= 1'b0;
      resp_reject <= 1'b0;
      resp_rdata  <= '0;
      rd_viol     <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_grant  <= req_valid && allow;
      resp_reject <= ev_reject;
      resp_rdata  <= (req_valid && (op == OP_READ) && allow) ? arr_rdata : '0;
      rd_viol     <= ev_rd_block;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prot_err <= 1'b0;
    else if (ev_reject) prot_err <= 1'b1;
    else if (err_clr)   prot_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_busy <= 1'b0;
      wp_held <= 1'b0;
    end else if (!pwr_ok) begin
      op_busy <= 1'b0;
    end else if (ev_start_pe) begin
      op_busy <= 1'b1;
      wp_held <= wp_level;
    end else if (op_done) begin
      op_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/lockgate_top.sv
module lockgate_top
  import lockgate_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS   = 16,
  parameter int unsigned SECT_PER_BLK = 16,
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned DATA_W       = 8,
  parameter bit          VARIANT_B    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              wp_level,
  input  logic              op_done,
  input  logic              lk_we,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_wdata,
  input  logic              err_clr,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_reject,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              rd_viol,
  output logic              prot_err,
  output logic              op_busy,
  output logic [1:0]        lk_rdata
);

  localparam int unsigned BLK_BITS    = $clog2(NUM_BLOCKS);
  localparam int unsigned SEC_BITS    = $clog2(SECT_PER_BLK);
  localparam int unsigned NUM_SPLIT   = 3;
  localparam int unsigned NUM_REGIONS = NUM_BLOCKS - NUM_SPLIT + NUM_SPLIT * SECT_PER_BLK;
  localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);
  localparam int unsigned BLK_LSB     = ADDR_W - BLK_BITS;
  localparam int unsigned SEC_LSB     = BLK_LSB - SEC_BITS;

  logic [BLK_BITS-1:0] req_blk, lk_blk;
  logic [SEC_BITS-1:0] req_sec, lk_sec;
  logic [IDX_W-1:0]    req_idx, lk_idx;
  logic                req_top;
  lock_t               lock_req, lock_lk;
  logic                wp_held;
  logic                ev_start_pe;
  logic                ev_reject;

  assign req_blk = req_addr[ADDR_W-1:BLK_LSB];
  assign req_sec = req_addr[BLK_LSB-1:SEC_LSB];
  assign lk_blk  = lk_addr[ADDR_W-1:BLK_LSB];
  assign lk_sec  = lk_addr[BLK_LSB-1:SEC_LSB];
  assign req_top = (req_blk == BLK_BITS'(NUM_BLOCKS - 1));

  lockgate_map #(
    .NUM_BLOCKS(NUM_BLOCKS), .SECT_PER_BLK(SECT_PER_BLK), .VARIANT_B(VARIANT_B),
    .BLK_BITS(BLK_BITS), .SEC_BITS(SEC_BITS), .IDX_W(IDX_W)
  ) u_map_req (
    .blk(req_blk), .sec(req_sec), .idx(req_idx)
  );

  lockgate_map #(
    .NUM_BLOCKS(NUM_BLOCKS), .SECT_PER_BLK(SECT_PER_BLK), .VARIANT_B(VARIANT_B),
    .BLK_BITS(BLK_BITS), .SEC_BITS(SEC_BITS), .IDX_W(IDX_W)
  ) u_map_lk (
    .blk(lk_blk), .sec(lk_sec), .idx(lk_idx)
  );

  lockgate_regs #(
    .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .we(lk_we), .widx(lk_idx), .wdata(lock_t'(lk_wdata)),
    .ridx_req(req_idx), .ridx_lk(lk_idx),
    .lock_req(lock_req), .lock_lk(lock_lk)
  );

  lockgate_decide #(
    .DATA_W(DATA_W)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .req_valid(req_valid), .req_op(req_op), .req_top(req_top), .lock(lock_req),
    .wp_level(wp_level), .op_done(op_done), .arr_rdata(arr_rdata), .err_clr(err_clr),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_reject(resp_reject),
    .resp_rdata(resp_rdata), .rd_viol(rd_viol), .prot_err(prot_err),
    .op_busy(op_busy), .wp_held(wp_held),
    .ev_start_pe(ev_start_pe), .ev_reject(ev_reject)
  );

  assign lk_rdata = lock_lk;

endmodule

// File: rtl/lockgate_chk.sv
module lockgate_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_ok,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              req_top,
  input logic              wp_level,
  input logic              op_done,
  input logic              err_clr,
  input logic              ev_start_pe,
  input logic              ev_reject,
  input logic              wp_held,
  input logic              resp_valid,
  input logic              resp_grant,
  input logic              resp_reject,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              rd_viol,
  input logic              prot_err,
  input logic              op_busy,
  input logic [1:0]        lk_rdata
);

  assert_req_gives_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_req_no_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !resp_grant && !resp_reject);

  assert_single_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_grant != resp_reject));

  assert_rsvd_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 2'b11) |=> resp_reject);

  assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 2'b01 || req_op == 2'b10) && !op_busy && !wp_level && !req_top
    |=> resp_reject);

  assert_viol_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |-> resp_reject && (resp_rdata == '0));

  assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_pe && pwr_ok |=> op_busy && (wp_held == $past(wp_level)));

  assert_held_wp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy && !op_done && pwr_ok |=> op_busy && $stable(wp_held));

  assert_pwr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (lk_rdata == 2'b00) && !op_busy);

  assert_reject_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> prot_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err && !err_clr |=> prot_err);

endmodule

bind lockgate_top lockgate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_valid(req_valid), .req_op(req_op),
  .req_top(req_top), .wp_level(wp_level), .op_done(op_done), .err_clr(err_clr),
  .ev_start_pe(ev_start_pe), .ev_reject(ev_reject), .wp_held(wp_held),
  .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_reject(resp_reject),
  .resp_rdata(resp_rdata), .rd_viol(rd_viol), .prot_err(prot_err),
  .op_busy(op_busy), .lk_rdata(lk_rdata)
);

// File: tb/tb_lockgate_top.sv
module tb_lockgate_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n, pwr_ok, req_valid, wp_level, op_done, lk_we, err_clr;
  logic [19:0] req_addr, lk_addr;
  logic [1:0]  req_op, lk_wdata;
  logic [7:0]  arr_rdata;

  logic       rv [2], rg [2], rr [2], vio [2], perr [2], bsy [2];
  logic [7:0] rdat [2];
  logic [1:0] lkr [2];

  lockgate_top #(.VARIANT_B(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .arr_rdata(arr_rdata), .wp_level(wp_level), .op_done(op_done),
    .lk_we(lk_we), .lk_addr(lk_addr), .lk_wdata(lk_wdata), .err_clr(err_clr),
    .resp_valid(rv[0]), .resp_grant(rg[0]), .resp_reject(rr[0]), .resp_rdata(rdat[0]),
    .rd_viol(vio[0]), .prot_err(perr[0]), .op_busy(bsy[0]), .lk_rdata(lkr[0]));

  lockgate_top #(.VARIANT_B(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .arr_rdata(arr_rdata), .wp_level(wp_level), .op_done(op_done),
    .lk_we(lk_we), .lk_addr(lk_addr), .lk_wdata(lk_wdata), .err_clr(err_clr),
    .resp_valid(rv[1]), .resp_grant(rg[1]), .resp_reject(rr[1]), .resp_rdata(rdat[1]),
    .rd_viol(vio[1]), .prot_err(perr[1]), .op_busy(bsy[1]), .lk_rdata(lkr[1]));

  // Reference model: one lock value per 4 KByte sector; a lock write to an
  // unsplit block is copied into all of its sectors.
  logic [1:0] m_lk [2][256];
  logic       m_busy [2], m_wph [2], m_err [2];
  logic       e_valid [2], e_grant [2], e_reject [2], e_viol [2];
  logic [7:0] e_rdata [2];

  int checks = 0;
  int fails  = 0;

  function automatic bit split_blk(int v, int b);
    if (v == 0) return (b == 0) || (b == 14) || (b == 15);
    return (b == 0) || (b == 1) || (b == 15);
  endfunction

  task automatic model_step();
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        for (int s = 0; s < 256; s++) m_lk[v][s] = 2'b00;
        m_busy[v] = 0; m_wph[v] = 0; m_err[v] = 0;
        e_valid[v] = 0; e_grant[v] = 0; e_reject[v] = 0; e_viol[v] = 0; e_rdata[v] = 0;
      end else begin
        int   blk;
        logic [1:0] lk;
        logic wpe, ok, pe;
        blk = int'(req_addr[19:16]);
        lk  = m_lk[v][req_addr[19:12]];
        wpe = m_busy[v] ? m_wph[v] : wp_level;
        pe  = (req_op == 2'b01) || (req_op == 2'b10);
        if (req_op == 2'b00)  ok = !lk[1];
        else if (pe)          ok = !lk[0] && (wpe || blk == 15);
        else                  ok = 0;
        e_valid[v]  = req_valid;
        e_grant[v]  = req_valid && ok;
        e_reject[v] = req_valid && !ok;
        e_viol[v]   = req_valid && !ok && (req_op == 2'b00);
        e_rdata[v]  = (req_valid && ok && req_op == 2'b00) ? arr_rdata : 8'h00;
        if (req_valid && !ok) m_err[v] = 1;
        else if (err_clr)     m_err[v] = 0;
        if (!pwr_ok) m_busy[v] = 0;
        else if (req_valid && ok && pe && !m_busy[v]) begin m_busy[v] = 1; m_wph[v] = wp_level; end
        else if (op_done) m_busy[v] = 0;
        if (!pwr_ok) begin
          for (int s = 0; s < 256; s++) m_lk[v][s] = 2'b00;
        end else if (lk_we) begin
          if (split_blk(v, int'(lk_addr[19:16]))) m_lk[v][lk_addr[19:12]] = lk_wdata;
          else for (int s = 0; s < 16; s++) m_lk[v][{lk_addr[19:16], 4'(s)}] = lk_wdata;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    for (int v = 0; v < 2; v++) begin
      logic [15:0] act, exp;
      act = {rv[v], rg[v], rr[v], rdat[v], vio[v], perr[v], bsy[v], lkr[v]};
      exp = {e_valid[v], e_grant[v], e_reject[v], e_rdata[v], e_viol[v], m_err[v], m_busy[v],
             m_lk[v][lk_addr[19:12]]};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s variant %0d: actual %h expected %h", tag, v, act, exp);
      end
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    req_valid = 0; lk_we = 0; op_done = 0; err_clr = 0; pwr_ok = 1;
  endtask

  task automatic req(logic [1:0] op, logic [19:0] a, string tag);
    quiet(); req_valid = 1; req_op = op; req_addr = a; cyc(tag);
  endtask

  task automatic lkw(logic [19:0] a, logic [1:0] d, string tag);
    quiet(); lk_we = 1; lk_addr = a; lk_wdata = d; cyc(tag);
  endtask

  task automatic look(logic [19:0] a, string tag);
    quiet(); lk_addr = a; cyc(tag);
  endtask

  task automatic done_pulse(string tag);
    quiet(); op_done = 1; cyc(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; quiet(); req_op = 0; req_addr = 0; lk_addr = 0; lk_wdata = 0;
    arr_rdata = 8'h5A; wp_level = 1;
    cyc("R9 reset"); cyc("R9 reset");
    rst_n = 1;
    look(20'hF_2000, "R9 reset locks clear");
    look(20'h3_0000, "R9 reset locks clear");

    // Pin behaviour
    req(2'b01, 20'h3_1000, "R6 program unlocked"); done_pulse("R8 done");
    wp_level = 0;
    req(2'b01, 20'h3_1000, "R4 program wp low");
    req(2'b10, 20'hE_0000, "R4 erase wp low");
    req(2'b10, 20'h0_4000, "R4 erase block0 wp low");
    req(2'b01, 20'hF_8000, "R5 top block wp low"); done_pulse("R8 done");
    quiet(); err_clr = 1; cyc("R10 clear");
    wp_level = 1;
    req(2'b10, 20'hF_8000, "R5 top block wp high"); done_pulse("R8 done");

    // Map and lock registers
    lkw(20'h3_5000, 2'b01, "R2 write-lock uniform block");
    look(20'h3_0000, "R1 whole block shares register");
    look(20'h3_F000, "R1 whole block shares register");
    lkw(20'hE_1000, 2'b01, "R1 block14 split in A only");
    look(20'hE_1000, "R1 block14 sector1");
    look(20'hE_2000, "R1 block14 sector2");
    lkw(20'h1_3000, 2'b10, "R1 block1 split in B only");
    look(20'h1_0000, "R1 block1 sector0");
    lkw(20'hF_2000, 2'b10, "R2 read-lock top sector");
    look(20'hF_3000, "R1 top neighbour sector");
    look(20'hF_2FFF, "R2 readback");

    req(2'b01, 20'h3_8000, "R6 write-locked block");
    req(2'b10, 20'h4_0000, "R6 unlocked block"); done_pulse("R8 done");
    req(2'b01, 20'hE_2000, "R6 block14 sector2");  done_pulse("R8 done");
    req(2'b10, 20'hE_1000, "R6 block14 sector1");  done_pulse("R8 done");

    // Reads
    arr_rdata = 8'hA5;
    req(2'b00, 20'hF_2010, "R7 read-locked sector");
    req(2'b00, 20'h3_0000, "R7 read ignores write-lock");
    wp_level = 0; arr_rdata = 8'h3C;
    req(2'b00, 20'h5_0000, "R7 read ignores wp");
    req(2'b00, 20'h1_0000, "R7 block1 sector0 read");
    wp_level = 1;
    req(2'b11, 20'h5_0000, "R3 reserved op");

    // Held write-protect
    quiet(); err_clr = 1; cyc("R10 clear");
    req(2'b01, 20'h5_0000, "R8 start with wp high");
    wp_level = 0;
    req(2'b01, 20'h6_0000, "R8 held level used");
    req(2'b10, 20'h7_0000, "R8 held level used");
    done_pulse("R8 done clears busy");
    req(2'b01, 20'h6_0000, "R8 live level after done");
    wp_level = 1;

    // Same-cycle lock write and request
    quiet(); req_valid = 1; req_op = 2'b01; req_addr = 20'h7_2000;
    lk_we = 1; lk_addr = 20'h7_0000; lk_wdata = 2'b01;
    cyc("R11 old lock value used");
    done_pulse("R8 done");
    req(2'b01, 20'h7_2000, "R11 new lock value");

    // Sticky error
    quiet(); req_valid = 1; req_op = 2'b11; err_clr = 1; cyc("R10 set beats clear");
    cyc("R10 hold");
    quiet(); cyc("R10 sticky");
    quiet(); err_clr = 1; cyc("R10 cleared");

    // Power drop
    req(2'b01, 20'h8_0000, "R8 busy before power drop");
    quiet(); pwr_ok = 0; lk_we = 1; lk_addr = 20'h9_0000; lk_wdata = 2'b11;
    cyc("R9 power drop");
    look(20'h3_0000, "R9 locks cleared");
    look(20'h9_0000, "R9 write discarded");
    look(20'hF_2000, "R9 locks cleared");

    // Mixed random phase
    for (int i = 0; i < 3000; i++) begin
      quiet();
      req_valid = ($urandom % 3) != 0;
      req_op    = 2'($urandom);
      req_addr  = {4'($urandom), 4'($urandom), 12'($urandom)};
      lk_we     = ($urandom % 4) == 0;
      lk_addr   = (($urandom % 2) == 0) ? req_addr : {4'($urandom), 4'($urandom), 12'h000};
      lk_wdata  = 2'($urandom);
      wp_level  = ($urandom % 4) != 0;
      op_done   = ($urandom % 5) == 0;
      err_clr   = ($urandom % 6) == 0;
      pwr_ok    = ($urandom % 97) != 0;
      arr_rdata = 8'($urandom);
      cyc("R6 mixed");
    end
    finish_run();
  end

endmodule